// File: doc/BRIEF.md
# Vertical Polyphase Line Filter

This block resamples one colour component of a video stream in the vertical direction. It keeps the previous input lines in its own line storage and blends pixels that sit in the same column across those lines. The weights come from a symmetric kernel. Six programmable reference points define the kernel, and the block interpolates it to 64 sub-line phases. A phase generator outside the block supplies one 6-bit phase for each output line. That phase arrives together with the first pixel of the line.

How many lines are blended depends on the active line width, which is latched at the start of each frame. For narrow lines the storage is split into two half-size line buffers and the block uses three taps. For wide lines the storage holds one full-width line and the block falls back to two taps. In two-tap mode the weights are renormalised so that they always sum to unity. Each result is rounded, clamped to the pixel range and sent out two cycles after its input pixel.

Top module: `vert_poly_filter`

## Requirements
- R1: At a `frame_start` pulse the block latches the tap mode: three taps when `cfg_width` is at most 1024, two taps otherwise. Changes on `cfg_width` at any other time have no effect until the next `frame_start`.
- R2: The kernel value K(d) for a distance d from 0 to 127, in 1/64-line units, is piecewise linear. Reference register k (address 0 to 5) gives the value at distance 0, 16, 32, 64, 96 and 128 in turn. Between two knots the value is r_k + floor((r_{k+1} - r_k) * (d - knot_k) / (knot_{k+1} - knot_k)). Reference values are 8-bit two's complement with 6 fractional bits (-128..127 means -2 to +1 63/64), and K(-d) = K(d).
- R3: In three-tap mode, for phase p the weights are K(64+p) on line L-2, K(p) on line L-1 and K(64-p) on the current line L.
- R4: In two-tap mode, for phase p the weight on line L-1 is K(p) and the weight on line L is 64 - K(p). No weight is given to line L-2.
- R5: Each output is floor((sum of weight*pixel + 32) / 64), clamped to 0..255.
- R6: On the first line of a frame every missing line is replaced by the current line. On the second line, line L-2 is replaced by line L-1 (the top line). Data stored before the frame is never used.
- R7: `out_valid` is high exactly two clock cycles after each cycle with `pix_valid` high, and low otherwise.
- R8: The weights are computed from `line_phase` and the reference registers only in the cycle where `pix_valid` and `pix_sol` are both high. A reference write during a line takes effect from the next line. `line_phase` is ignored on every other pixel.
- R9: After reset `out_valid` and `out_data` are 0 and the reference registers hold 64, 48, 32, 0, 0, 0 (addresses 0 to 5), which gives a linear kernel 64 - d over distances 0..64.
- R10: In two-tap mode lines of up to 2048 pixels are stored in full, so pixels at columns 1024 and above are filtered against their own column of line L-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Frame boundary pulse; never in the same cycle as `pix_valid` |
| cfg_width | input | 12 | Active line width in pixels |
| ref_we | input | 1 | Reference-point write strobe |
| ref_addr | input | 3 | Reference-point index 0..5 |
| ref_wdata | input | 8 | Signed reference value, 6 fractional bits |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_sol | input | 1 | Marks the first pixel of a line |
| pix_data | input | 8 | Input pixel |
| line_phase | input | 6 | Output-line phase, sampled with the first pixel |
| out_valid | output | 1 | Output pixel qualifier |
| out_data | output | 8 | Filtered pixel |

## Verification
The filter is driven with column ramps, columns alternating between 0 and 255, flat full-scale lines and pseudo-random pixels, at phases spread across all 64 values. Ramps and random data show whether each tap reads the correct stored line and whether the weights differ between phases. The alternating and flat patterns push the sum past both clamp limits. A kernel whose reference points swing between extremes makes every interpolation segment give a different value, so an error in a knot position or in the rounding shows up. Frames at widths 1024 and 1025 with lines of 1100 pixels separate the two tap modes and the upper half of the storage. Changes to the width and to the phase during a frame, and a reference write in the middle of a line, show which inputs are sampled and when.

// File: rtl/vpf_pkg.sv
// Package: shared widths and the knot layout of the vertical kernel.
// Assumes one 8-bit colour component and 6-bit phases.
package vpf_pkg;
    localparam int PIX_W  = 8;
    localparam int REF_W  = 8;
    localparam int FRAC   = 6;
    localparam int NREF   = 6;
    localparam int PH_W   = 6;
    localparam int CW     = 10;              // internal weight width
    localparam int DIST_W = PH_W + 1;        // distance 0..127
    localparam int ACC_W  = CW + PIX_W + 3;

    // Distance (1/64 line units) at which reference point k sits.
    function automatic int knot_pos(input int k);
        case (k)
            0:       return 0;
            1:       return 16;
            2:       return 32;
            3:       return 64;
            4:       return 96;
            default: return 128;
        endcase
    endfunction

    // log2 of the width of segment k (knot k to knot k+1).
    function automatic int seg_shift(input int k);
        return (k < 2) ? 4 : 5;
    endfunction
endpackage

// File: rtl/vpf_line_ram.sv
// Module: one line-buffer bank, single address, read-before-write.
// Assumes a synchronous read: rdata shows the old word one cycle after addr.
module vpf_line_ram #(
    parameter int DEPTH = 1024,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Read the stored word and then overwrite it on the same edge.
    always_ff @(posedge clk) begin
        rdata <= mem[addr];
        if (we) begin
            mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/vpf_line_ctl.sv
// Module: frame/line sequencing. Latches the tap mode at frame start,
// counts columns and rows, and routes writes to the two storage banks.
// Assumes frame_start never coincides with pix_valid and that all lines of
// a frame have the same length.
module vpf_line_ctl #(
    parameter int MAX_W = 2048,
    localparam int HALF = MAX_W / 2,
    localparam int HA   = $clog2(HALF),
    localparam int XW   = $clog2(MAX_W),
    localparam int WW   = XW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic [WW-1:0] cfg_width,
    input  logic          pix_valid,
    input  logic          pix_sol,
    output logic          three_tap,
    output logic [1:0]    row_now,
    output logic [HA-1:0] bank_addr,
    output logic [1:0]    bank_we,
    output logic          n1_hi
);
    logic          three_q;
    logic          started_q;
    logic [1:0]    row_q;
    logic          par_q;
    logic [XW-1:0] x_q;
    logic [XW-1:0] x_now;
    logic          par_now;

    // Column, row and bank parity that the current pixel belongs to.
    always_comb begin
        x_now   = pix_sol ? '0 : x_q;
        row_now = row_q;
        par_now = par_q;
        if (pix_sol) begin
            if (started_q) begin
                row_now = (row_q == 2'd2) ? 2'd2 : row_q + 2'd1;
                par_now = ~par_q;
            end else begin
                row_now = 2'd0;
                par_now = 1'b0;
            end
        end
    end

    // Bank write enables and the bank that holds line L-1.
    always_comb begin
        bank_addr = x_now[HA-1:0];
        if (three_q) begin
            bank_we = pix_valid ? {par_now, ~par_now} : 2'b00;
            n1_hi   = ~par_now;
        end else begin
            bank_we = pix_valid ? {x_now[HA], ~x_now[HA]} : 2'b00;
            n1_hi   = x_now[HA];
        end
    end

    // Sequencing state: mode latch at frame start, counters per pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            three_q   <= 1'b1;
            started_q <= 1'b0;
            row_q     <= 2'd0;
            par_q     <= 1'b0;
            x_q       <= '0;
        end else if (frame_start) begin
            three_q   <= (cfg_width <= WW'(HALF));
            started_q <= 1'b0;
            row_q     <= 2'd0;
            par_q     <= 1'b0;
            x_q       <= '0;
        end else if (pix_valid) begin
            x_q   <= x_now + XW'(1);
            row_q <= row_now;
            par_q <= par_now;
            if (pix_sol) begin
                started_q <= 1'b1;
            end
        end
    end

    assign three_tap = three_q;
endmodule

// File: rtl/vpf_kernel.sv
// Module: reference-point registers and per-line weight generation.
// Interpolates the symmetric kernel at the three tap distances and latches
// the weights with the first pixel of each line.
module vpf_kernel
    import vpf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ref_we,
    input  logic [2:0]           ref_addr,
    input  logic [REF_W-1:0]     ref_wdata,
    input  logic                 load,
    input  logic [PH_W-1:0]      phase,
    input  logic                 three_tap,
    output logic signed [CW-1:0] c_top,
    output logic signed [CW-1:0] c_mid,
    output logic signed [CW-1:0] c_bot
);
    logic [NREF*REF_W-1:0] refs_q;
    logic signed [CW-1:0]  k_far;
    logic signed [CW-1:0]  k_near;
    logic signed [CW-1:0]  k_opp;

    // Piecewise-linear kernel value at distance d.
    function automatic logic signed [CW-1:0] kern(
        input logic [NREF*REF_W-1:0] rf,
        input logic [DIST_W-1:0]     d
    );
        int seg;
        int lo;
        int hi;
        int acc;
        seg = 0;
        for (int k = 1; k < NREF - 1; k++) begin
            if (int'(d) >= knot_pos(k)) begin
                seg = k;
            end
        end
        lo  = int'($signed(rf[seg*REF_W +: REF_W]));
        hi  = int'($signed(rf[(seg+1)*REF_W +: REF_W]));
        acc = (hi - lo) * (int'(d) - knot_pos(seg));
        return CW'(lo + (acc >>> seg_shift(seg)));
    endfunction

    // Kernel samples at the distances of the three taps.
    always_comb begin
        k_far  = kern(refs_q, {1'b1, phase});
        k_near = kern(refs_q, {1'b0, phase});
        k_opp  = kern(refs_q, DIST_W'(7'd64 - {1'b0, phase}));
    end

    // Reference register file; writes beyond the last point are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refs_q <= {8'sd0, 8'sd0, 8'sd0, 8'sd32, 8'sd48, 8'sd64};
        end else if (ref_we && (int'(ref_addr) < NREF)) begin
            refs_q[ref_addr*REF_W +: REF_W] <= ref_wdata;
        end
    end

    // Weight latch, updated only with the first pixel of a line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_top <= '0;
            c_mid <= CW'(64);
            c_bot <= '0;
        end else if (load) begin
            c_mid <= k_near;
            if (three_tap) begin
                c_top <= k_far;
                c_bot <= k_opp;
            end else begin
                c_top <= '0;
                c_bot <= CW'(64) - k_near;
            end
        end
    end
endmodule

// File: rtl/vpf_mac.sv
// Module: tap selection, weighted sum, rounding and clamping.
// Stage 1 lines up the current pixel with the stored lines read from the
// banks; stage 2 registers the clamped result.
module vpf_mac
    import vpf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s0_valid,
    input  logic [PIX_W-1:0]     s0_pix,
    input  logic [1:0]           s0_row,
    input  logic                 s0_n1_hi,
    input  logic [PIX_W-1:0]     rd_lo,
    input  logic [PIX_W-1:0]     rd_hi,
    input  logic signed [CW-1:0] c_top,
    input  logic signed [CW-1:0] c_mid,
    input  logic signed [CW-1:0] c_bot,
    output logic                 out_valid,
    output logic [PIX_W-1:0]     out_data
);
    logic                    s1_valid;
    logic [PIX_W-1:0]        s1_pix;
    logic [1:0]              s1_row;
    logic                    s1_n1_hi;
    logic [PIX_W-1:0]        n1;
    logic [PIX_W-1:0]        n2;
    logic [PIX_W-1:0]        tap_top;
    logic [PIX_W-1:0]        tap_mid;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] rnd;
    logic [PIX_W-1:0]        sat;

    // Stage 1 register: current pixel and its row context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_pix   <= '0;
            s1_row   <= 2'd0;
            s1_n1_hi <= 1'b0;
        end else begin
            s1_valid <= s0_valid;
            s1_pix   <= s0_pix;
            s1_row   <= s0_row;
            s1_n1_hi <= s0_n1_hi;
        end
    end

    // Pick stored lines, replicating the top line at the frame start.
    always_comb begin
        n1 = s1_n1_hi ? rd_hi : rd_lo;
        n2 = s1_n1_hi ? rd_lo : rd_hi;
        case (s1_row)
            2'd0: begin
                tap_top = s1_pix;
                tap_mid = s1_pix;
            end
            2'd1: begin
                tap_top = n1;
                tap_mid = n1;
            end
            default: begin
                tap_top = n2;
                tap_mid = n1;
            end
        endcase
    end

    // Weighted sum, round to nearest with ties up, clamp to pixel range.
    always_comb begin
        acc = ACC_W'(c_top * $signed({1'b0, tap_top}))
            + ACC_W'(c_mid * $signed({1'b0, tap_mid}))
            + ACC_W'(c_bot * $signed({1'b0, s1_pix}));
        rnd = (acc + ACC_W'(1 << (FRAC - 1))) >>> FRAC;
        if (rnd < 0) begin
            sat = '0;
        end else if (rnd > ACC_W'((1 << PIX_W) - 1)) begin
            sat = '1;
        end else begin
            sat = rnd[PIX_W-1:0];
        end
    end

    // Stage 2 register: filtered output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_data <= sat;
            end
        end
    end
endmodule

// File: rtl/vert_poly_filter.sv
// Module: vertical polyphase filter top. Two half-width banks serve as two
// line buffers in three-tap mode or as one full-width line in two-tap mode.
// Assumes one phase per line, supplied with the first pixel of the line.
module vert_poly_filter
    import vpf_pkg::*;
#(
    parameter int MAX_W = 2048,
    localparam int HALF = MAX_W / 2,
    localparam int HA   = $clog2(HALF),
    localparam int WW   = $clog2(MAX_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [WW-1:0]    cfg_width,
    input  logic             ref_we,
    input  logic [2:0]       ref_addr,
    input  logic [REF_W-1:0] ref_wdata,
    input  logic             pix_valid,
    input  logic             pix_sol,
    input  logic [PIX_W-1:0] pix_data,
    input  logic [PH_W-1:0]  line_phase,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_data
);
    logic                 three_tap;
    logic [1:0]           row_now;
    logic [HA-1:0]        bank_addr;
    logic [1:0]           bank_we;
    logic                 n1_hi;
    logic [PIX_W-1:0]     bank_rd [2];
    logic signed [CW-1:0] c_top;
    logic signed [CW-1:0] c_mid;
    logic signed [CW-1:0] c_bot;

    vpf_line_ctl #(.MAX_W(MAX_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .cfg_width  (cfg_width),
        .pix_valid  (pix_valid),
        .pix_sol    (pix_sol),
        .three_tap  (three_tap),
        .row_now    (row_now),
        .bank_addr  (bank_addr),
        .bank_we    (bank_we),
        .n1_hi      (n1_hi)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        vpf_line_ram #(.DEPTH(HALF), .W(PIX_W)) u_ram (
            .clk  (clk),
            .we   (bank_we[b]),
            .addr (bank_addr),
            .wdata(pix_data),
            .rdata(bank_rd[b])
        );
    end

    vpf_kernel u_kernel (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_we   (ref_we),
        .ref_addr (ref_addr),
        .ref_wdata(ref_wdata),
        .load     (pix_valid & pix_sol),
        .phase    (line_phase),
        .three_tap(three_tap),
        .c_top    (c_top),
        .c_mid    (c_mid),
        .c_bot    (c_bot)
    );

    vpf_mac u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .s0_valid (pix_valid),
        .s0_pix   (pix_data),
        .s0_row   (row_now),
        .s0_n1_hi (n1_hi),
        .rd_lo    (bank_rd[0]),
        .rd_hi    (bank_rd[1]),
        .c_top    (c_top),
        .c_mid    (c_mid),
        .c_bot    (c_bot),
        .out_valid(out_valid),
        .out_data (out_data)
    );
endmodule

// File: rtl/vpf_checker.sv
// Module: protocol and timing checks, bound into the filter top.
module vpf_checker
    import vpf_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_start,
    input logic                 pix_valid,
    input logic                 pix_sol,
    input logic                 out_valid,
    input logic                 three_tap,
    input logic signed [CW-1:0] c_top,
    input logic signed [CW-1:0] c_mid,
    input logic signed [CW-1:0] c_bot
);
    logic [1:0] age;

    // Cycles since reset, saturating, so history checks stay after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (out_valid == $past(pix_valid, 2))); // R7

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(three_tap)); // R1

    AST_WEIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_valid && pix_sol) |=> $stable({c_top, c_mid, c_bot})); // R8

    AST_PAIR_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_sol && !three_tap) |=>
            (c_top == '0 && ($signed({c_mid[CW-1], c_mid}) + $signed({c_bot[CW-1], c_bot})) == (CW+1)'(64))); // R4
endmodule

bind vert_poly_filter vpf_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .pix_valid  (pix_valid),
    .pix_sol    (pix_sol),
    .out_valid  (out_valid),
    .three_tap  (three_tap),
    .c_top      (c_top),
    .c_mid      (c_mid),
    .c_bot      (c_bot)
);

// File: tb/test_vert_poly_filter.sv
// Bench: behavioural line-history model compared with the outputs every cycle.
module test_vert_poly_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic [11:0] cfg_width = 12'd0;
    logic        ref_we = 1'b0;
    logic [2:0]  ref_addr = 3'd0;
    logic [7:0]  ref_wdata = 8'd0;
    logic        pix_valid = 1'b0;
    logic        pix_sol = 1'b0;
    logic [7:0]  pix_data = 8'd0;
    logic [5:0]  line_phase = 6'd0;
    logic        out_valid;
    logic [7:0]  out_data;

    always #5 clk = ~clk;

    vert_poly_filter i_vert_poly_filter (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_width(cfg_width),
        .ref_we(ref_we), .ref_addr(ref_addr), .ref_wdata(ref_wdata),
        .pix_valid(pix_valid), .pix_sol(pix_sol), .pix_data(pix_data),
        .line_phase(line_phase), .out_valid(out_valid), .out_data(out_data)
    );

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    int    exp_due[$];
    int    exp_val[$];
    string exp_req[$];

    // model state
    int refs[6] = '{64, 48, 32, 0, 0, 0};
    bit m_three = 1'b1;
    bit m_started = 1'b0;
    int m_row = 0;
    int m_ct, m_cm, m_cb;
    int prev1[2048];
    int prev2[2048];
    int curl[2048];
    int line_no = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    // Every-cycle comparison against the model's expected stream (R7, R5 ...).
    always @(negedge clk) begin
        if (checking) begin
            if (exp_due.size() > 0 && exp_due[0] == cyc) begin
                chk(out_valid === 1'b1, "R7", "out_valid", int'(out_valid), 1);
                chk(out_data === 8'(exp_val[0]), exp_req[0], "out_data", int'(out_data), exp_val[0]);
                void'(exp_due.pop_front());
                void'(exp_val.pop_front());
                void'(exp_req.pop_front());
            end else begin
                chk(out_valid === 1'b0, "R7", "idle out_valid", int'(out_valid), 0);
            end
        end
    end

    function automatic int fdiv(input int a, input int b);
        int q;
        q = a / b;
        if ((a % b) != 0 && a < 0) q = q - 1;
        return q;
    endfunction

    // Kernel value from the requirement (R2): knots 0,16,32,64,96,128.
    function automatic int kfun(input int d);
        int kp[6] = '{0, 16, 32, 64, 96, 128};
        for (int j = 0; j < 5; j++) begin
            if (d >= kp[j] && d < kp[j+1])
                return refs[j] + fdiv((refs[j+1] - refs[j]) * (d - kp[j]), kp[j+1] - kp[j]);
        end
        return 0;
    endfunction

    function automatic int pixval(input int pat, input int x, input int ln);
        case (pat)
            0: return (x * 7 + ln * 29) & 255;
            1: return (x % 2 == 1) ? 255 : 0;
            2: return 255;
            default: return (x * 131 + ln * 57 + 17) & 255;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_ref(input int a, input int v);
        ref_we = 1'b1;
        ref_addr = 3'(a);
        ref_wdata = 8'(v);
        refs[a] = v;
        tick();
        ref_we = 1'b0;
    endtask

    // Frame start: mode latched from width (R1).
    task automatic frame(input int w);
        frame_start = 1'b1;
        cfg_width = 12'(w);
        m_three = (w <= 1024);
        m_started = 1'b0;
        m_row = 0;
        tick();
        frame_start = 1'b0;
        tick();
    endtask

    task automatic send_line(input int ph, input int n, input int pat, input string req,
                             input int wr_at, input int wr_a, input int wr_v, input bit gap);
        int top, mid, bot, sum, res;
        if (m_started) begin
            prev2 = prev1;
            prev1 = curl;
            m_row = (m_row < 2) ? m_row + 1 : 2;
        end else begin
            m_row = 0;
            m_started = 1'b1;
        end
        if (m_three) begin
            m_ct = kfun(64 + ph);
            m_cm = kfun(ph);
            m_cb = kfun(64 - ph);
        end else begin
            m_ct = 0;
            m_cm = kfun(ph);
            m_cb = 64 - kfun(ph);
        end
        for (int x = 0; x < n; x++) begin
            if (gap && (x % 7 == 3)) begin
                pix_valid = 1'b0;
                pix_sol = 1'b0;
                ref_we = 1'b0;
                tick();
            end
            bot = pixval(pat, x, line_no);
            curl[x] = bot;
            if (m_row == 0) begin
                top = bot; mid = bot;
            end else if (m_row == 1) begin
                top = prev1[x]; mid = prev1[x];
            end else begin
                top = prev2[x]; mid = prev1[x];
            end
            sum = m_ct * top + m_cm * mid + m_cb * bot;
            res = fdiv(sum + 32, 64);
            if (res < 0) res = 0;
            if (res > 255) res = 255;
            pix_valid = 1'b1;
            pix_sol = (x == 0);
            pix_data = 8'(bot);
            line_phase = (x == 0) ? 6'(ph) : 6'((x * 13 + 5) & 63); // R8: ignored mid-line
            if (x == wr_at) begin
                ref_we = 1'b1;
                ref_addr = 3'(wr_a);
                ref_wdata = 8'(wr_v);
                refs[wr_a] = wr_v;
            end else begin
                ref_we = 1'b0;
            end
            exp_due.push_back(cyc + 2);
            exp_val.push_back(res);
            exp_req.push_back(req);
            tick();
        end
        pix_valid = 1'b0;
        pix_sol = 1'b0;
        ref_we = 1'b0;
        line_no++;
        repeat (3) tick();
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", exp_due.size(), 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R9: reset state of the outputs.
        chk(out_valid === 1'b0, "R9", "reset out_valid", int'(out_valid), 0);
        chk(out_data === 8'd0, "R9", "reset out_data", int'(out_data), 0);
        rst_n = 1'b1;
        tick();
        checking = 1'b1;

        // R3, R6, R9: reset kernel (linear), three taps, phases across the range.
        frame(40);
        send_line(0, 40, 0, "R6", -1, 0, 0, 1'b0);
        send_line(16, 40, 0, "R6", -1, 0, 0, 1'b1);
        send_line(32, 40, 0, "R3", -1, 0, 0, 1'b0);
        send_line(48, 40, 3, "R3", -1, 0, 0, 1'b1);
        send_line(63, 40, 3, "R9", -1, 0, 0, 1'b0);

        // R5: strong kernel, width exactly 1024 keeps three taps, clamping both ends.
        set_ref(0, 100); set_ref(1, 90); set_ref(2, 60);
        set_ref(3, -30); set_ref(4, -70); set_ref(5, -128);
        frame(1024);
        send_line(20, 1024, 1, "R5", -1, 0, 0, 1'b0);
        send_line(5, 1024, 2, "R5", -1, 0, 0, 1'b0);
        send_line(50, 1024, 1, "R5", -1, 0, 0, 1'b0);
        send_line(0, 1024, 2, "R5", -1, 0, 0, 1'b0);

        // R8: reference write mid-line takes effect at the next line.
        frame(200);
        send_line(33, 60, 3, "R8", -1, 0, 0, 1'b0);
        send_line(33, 60, 3, "R8", 30, 2, 10, 1'b0);
        send_line(33, 60, 3, "R8", 12, 1, -40, 1'b1);
        send_line(33, 60, 0, "R8", -1, 0, 0, 1'b0);

        // R4, R10, R1: width 1025 gives two taps; full 1100-pixel lines.
        set_ref(0, 64); set_ref(1, 50); set_ref(2, 40);
        set_ref(3, 10); set_ref(4, -5); set_ref(5, 0);
        frame(1025);
        cfg_width = 12'd64; // R1: ignored until the next frame start
        send_line(10, 1100, 3, "R4", -1, 0, 0, 1'b0);
        send_line(40, 1100, 0, "R10", -1, 0, 0, 1'b0);
        send_line(0, 1100, 3, "R10", -1, 0, 0, 1'b0);
        send_line(63, 1100, 1, "R4", -1, 0, 0, 1'b0);

        // R1, R6: back to three taps; stale banks must not leak in.
        frame(64);
        cfg_width = 12'd3000; // R1: ignored mid-frame
        send_line(7, 64, 3, "R6", -1, 0, 0, 1'b0);
        send_line(7, 64, 0, "R6", -1, 0, 0, 1'b0);
        send_line(7, 64, 3, "R1", -1, 0, 0, 1'b0);

        // R2: alternating extreme knots exercise every segment.
        set_ref(0, 127); set_ref(1, -128); set_ref(2, 127);
        set_ref(3, -128); set_ref(4, 127); set_ref(5, -128);
        frame(30);
        send_line(0, 30, 3, "R2", -1, 0, 0, 1'b0);
        send_line(9, 30, 0, "R2", -1, 0, 0, 1'b0);
        send_line(17, 30, 3, "R2", -1, 0, 0, 1'b0);
        send_line(31, 30, 3, "R2", -1, 0, 0, 1'b0);
        send_line(40, 30, 0, "R2", -1, 0, 0, 1'b0);
        send_line(55, 30, 3, "R2", -1, 0, 0, 1'b0);
        send_line(63, 30, 3, "R2", -1, 0, 0, 1'b0);
        send_line(24, 30, 0, "R2", -1, 0, 0, 1'b0);

        repeat (5) tick();
        chk(exp_due.size() == 0, "R7", "pending outputs", exp_due.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule